// File: doc/BRIEF.md
# Virtual Interrupt Flag Unit

This block keeps the interrupt-related flag bits of a 16-bit task that runs under a virtualizing supervisor: the real interrupt enable (IF), its shadow copy (VIF) and the pending-interrupt marker (VIP). It takes decoded flag operations (clear-interrupt, set-interrupt, push-flags, pop-flags) one at a time. Each is judged against the virtual-mode enable bit and the 2-bit I/O privilege level. The block then either updates a flag, produces the 16-bit image that a push writes to the stack, or raises a one-cycle general-protection fault request.

When virtual mode is enabled and the privilege level is below 3, the four operations are redirected onto VIF and IF is left alone. Any attempt to set VIF while VIP is 1 becomes a fault instead. With privilege level 3 the operations act on IF directly. With virtual mode off and privilege below 3, every one of them faults. VIP is changed only through a dedicated software write port.

Operations enter on a valid/ready stream. An operation is taken on a clock edge where `op_valid_i` and `op_ready_o` are both high. A push image leaves on a second valid/ready stream. `push_valid_o` and `push_data_o` hold steady until the edge where `push_ready_i` is high. While an image waits, `op_ready_o` is low, so the next operation is held back.

Top module: `vif_unit`

## Requirements
- R1: After reset, IF, VIF and VIP read 0, `fault_o` is 0 and `push_valid_o` is 0. In `flags_o`, IF is bit 9, the privilege level is bits 13:12, VIF is bit 19 and VIP is bit 20.
- R2: With `vme_i`=1 and `iopl_i`<3, op code 0 (clear) clears VIF. Op code 1 (set) sets VIF when VIP is 0. Neither changes IF.
- R3: With `vme_i`=1 and `iopl_i`<3, op code 2 (push) gives an image in which bit 9 equals VIF and bits 13:12 equal `iopl_i`. All other bits come from `base_flags_i`.
- R4: With `vme_i`=1 and `iopl_i`<3, op code 3 (pop) loads VIF from `pop_if_i` when that is allowed, and IF is unchanged.
- R5: With `vme_i`=1 and `iopl_i`<3, when VIP is 1, a set, or a pop with `pop_if_i`=1, raises a fault. IF and VIF stay unchanged and no image is pushed.
- R6: VIP changes only on an edge where `vip_wr_i` is 1, and it then takes `vip_wdata_i`. No operation alters it.
- R7: With `vme_i`=0 and `iopl_i`<3, every operation raises a fault, changes no flag and pushes nothing.
- R8: With `iopl_i`=3, clear and set write IF to 0 and 1, pop loads IF from `pop_if_i`, and push puts IF in image bit 9. None of them faults and VIF is unchanged.
- R9: A fault is a pulse of one cycle, in the cycle after the operation is taken.
- R10: A pushed image shows on `push_valid_o` the cycle after the push is taken. Data holds stable until it is taken, and `op_ready_o` is low while `push_valid_o` is high.
- R11: With `vme_i`=1 and `iopl_i`<3, clear, and a pop with `pop_if_i`=0, never fault, even when VIP is 1. Both leave VIF at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vme_i | input | 1 | Virtual-mode enable |
| iopl_i | input | 2 | I/O privilege level |
| base_flags_i | input | 16 | Remaining flag bits for the push image |
| op_valid_i | input | 1 | Operation offered |
| op_ready_o | output | 1 | Operation can be taken |
| op_code_i | input | 2 | 0 clear, 1 set, 2 push, 3 pop |
| pop_if_i | input | 1 | Interrupt bit of the popped image |
| push_valid_o | output | 1 | Push image available |
| push_ready_i | input | 1 | Stack side takes the image |
| push_data_o | output | 16 | Push image |
| vip_wr_i | input | 1 | Software write strobe for VIP |
| vip_wdata_i | input | 1 | Value written to VIP |
| flags_o | output | 32 | Flag view: IF, privilege level, VIF, VIP |
| fault_o | output | 1 | General-protection fault request |

## Verification
The assertions assume that `vme_i`, `iopl_i` and the op fields are steady around the edge where an operation is taken. They also assume that the stack side is free to stall the push stream at will. The stimulus changes these inputs only at falling edges. It offers each operation once `op_ready_o` is high, drops it after acceptance, and stalls the push stream for random spans of zero to three cycles. Random mode, privilege, op code, popped bit and base image are mixed with occasional VIP writes. Directed cases cover a set or pop under a pending VIP, and a clear under a pending VIP.

// File: rtl/vif_pkg.sv
package vif_pkg;
  typedef enum logic [1:0] {
    OP_CLI   = 2'd0,
    OP_STI   = 2'd1,
    OP_PUSHF = 2'd2,
    OP_POPF  = 2'd3
  } vif_op_e;

  typedef struct packed {
    logic if_f;
    logic vif_f;
    logic vip_f;
  } vif_state_t;

  typedef struct packed {
    logic fault;
    logic wr_if;
    logic if_val;
    logic wr_vif;
    logic vif_val;
    logic push;
    logic push_if;
  } vif_dec_t;
endpackage

// File: rtl/vif_policy.sv
module vif_policy
  import vif_pkg::*;
#(
  parameter int IOPL_W = 2
) (
  input  logic              vme,
  input  logic [IOPL_W-1:0] iopl,
  input  vif_op_e           op,
  input  logic              pop_if,
  input  vif_state_t        st,
  output vif_dec_t          dec
);
  logic top_priv;
  assign top_priv = &iopl;

  always_comb begin
    dec = '0;
    if (top_priv) begin
      unique case (op)
        OP_CLI:   begin dec.wr_if = 1'b1; dec.if_val = 1'b0; end
        OP_STI:   begin dec.wr_if = 1'b1; dec.if_val = 1'b1; end
        OP_PUSHF: begin dec.push = 1'b1; dec.push_if = st.if_f; end
        OP_POPF:  begin dec.wr_if = 1'b1; dec.if_val = pop_if; end
        default:  dec = '0;
      endcase
    end else if (!vme) begin
      dec.fault = 1'b1;
    end else begin
      unique case (op)
        OP_CLI: begin dec.wr_vif = 1'b1; dec.vif_val = 1'b0; end
        OP_STI: begin
          if (st.vip_f) dec.fault = 1'b1;
          else begin dec.wr_vif = 1'b1; dec.vif_val = 1'b1; end
        end
        OP_PUSHF: begin dec.push = 1'b1; dec.push_if = st.vif_f; end
        OP_POPF: begin
          if (pop_if && st.vip_f) dec.fault = 1'b1;
          else begin dec.wr_vif = 1'b1; dec.vif_val = pop_if; end
        end
        default: dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/vif_image_build.sv
module vif_image_build #(
  parameter int IMG_W   = 16,
  parameter int IF_POS  = 9,
  parameter int IOPL_LO = 12,
  parameter int IOPL_W  = 2
) (
  input  logic [IMG_W-1:0]  base,
  input  logic              if_bit,
  input  logic [IOPL_W-1:0] iopl,
  output logic [IMG_W-1:0]  img
);
  localparam int IOPL_HI = IOPL_LO + IOPL_W - 1;

  for (genvar b = 0; b < IMG_W; b++) begin : g_bit
    if (b == IF_POS) begin : g_if
      assign img[b] = if_bit;
    end else if (b >= IOPL_LO && b <= IOPL_HI) begin : g_iopl
      assign img[b] = iopl[b-IOPL_LO];
    end else begin : g_pass
      assign img[b] = base[b];
    end
  end
endmodule

// File: rtl/vif_flag_regs.sv
module vif_flag_regs
  import vif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  vif_dec_t   dec,
  input  logic       vip_wr,
  input  logic       vip_wdata,
  output vif_state_t st,
  output logic       fault_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= take && dec.fault;
      if (take && !dec.fault) begin
        if (dec.wr_if)  st.if_f  <= dec.if_val;
        if (dec.wr_vif) st.vif_f <= dec.vif_val;
      end
      if (vip_wr) st.vip_f <= vip_wdata;
    end
  end
endmodule

// File: rtl/vif_push_stage.sv
module vif_push_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vif_unit.sv
module vif_unit
  import vif_pkg::*;
#(
  parameter int IMG_W   = 16,
  parameter int FLAGS_W = 32,
  parameter int IOPL_W  = 2,
  parameter int IF_POS  = 9,
  parameter int IOPL_LO = 12,
  parameter int VIF_POS = 19,
  parameter int VIP_POS = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vme_i,
  input  logic [IOPL_W-1:0]  iopl_i,
  input  logic [IMG_W-1:0]   base_flags_i,
  input  logic               op_valid_i,
  output logic               op_ready_o,
  input  logic [1:0]         op_code_i,
  input  logic               pop_if_i,
  output logic               push_valid_o,
  input  logic               push_ready_i,
  output logic [IMG_W-1:0]   push_data_o,
  input  logic               vip_wr_i,
  input  logic               vip_wdata_i,
  output logic [FLAGS_W-1:0] flags_o,
  output logic               fault_o
);
  vif_state_t       st;
  vif_dec_t         dec;
  logic             take;
  logic [IMG_W-1:0] img;

  assign op_ready_o = !push_valid_o;
  assign take       = op_valid_i && op_ready_o;

  vif_policy #(.IOPL_W(IOPL_W)) policy_i (
    .vme(vme_i), .iopl(iopl_i), .op(vif_op_e'(op_code_i)),
    .pop_if(pop_if_i), .st(st), .dec(dec)
  );

  vif_image_build #(.IMG_W(IMG_W), .IF_POS(IF_POS), .IOPL_LO(IOPL_LO),
                    .IOPL_W(IOPL_W)) image_i (
    .base(base_flags_i), .if_bit(dec.push_if), .iopl(iopl_i), .img(img)
  );

  vif_flag_regs regs_i (
    .clk(clk), .rst_n(rst_n), .take(take), .dec(dec),
    .vip_wr(vip_wr_i), .vip_wdata(vip_wdata_i), .st(st), .fault_q(fault_o)
  );

  vif_push_stage #(.W(IMG_W)) push_i (
    .clk(clk), .rst_n(rst_n), .load(take && dec.push), .din(img),
    .ready(push_ready_i), .valid(push_valid_o), .dout(push_data_o)
  );

  always_comb begin
    flags_o                    = '0;
    flags_o[IF_POS]            = st.if_f;
    flags_o[IOPL_LO +: IOPL_W] = iopl_i;
    flags_o[VIF_POS]           = st.vif_f;
    flags_o[VIP_POS]           = st.vip_f;
  end
endmodule

// File: rtl/vif_unit_chk.sv
module vif_unit_chk #(
  parameter int IMG_W   = 16,
  parameter int FLAGS_W = 32,
  parameter int IOPL_W  = 2,
  parameter int IF_POS  = 9,
  parameter int VIF_POS = 19,
  parameter int VIP_POS = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vme_i,
  input logic [IOPL_W-1:0]  iopl_i,
  input logic               op_valid_i,
  input logic               op_ready_o,
  input logic [1:0]         op_code_i,
  input logic               push_valid_o,
  input logic               push_ready_i,
  input logic [IMG_W-1:0]   push_data_o,
  input logic               vip_wr_i,
  input logic [FLAGS_W-1:0] flags_o,
  input logic               fault_o
);
  logic take;
  assign take = op_valid_i && op_ready_o;

  AST_FAULT_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(take)); // R9
  AST_FAULT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $stable(flags_o[IF_POS]) && $stable(flags_o[VIF_POS])); // R5
  AST_FAULT_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !push_valid_o); // R5
  AST_VIP_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !vip_wr_i |=> $stable(flags_o[VIP_POS])); // R6
  AST_NOVIRT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    take && !vme_i && !(&iopl_i) |=> fault_o); // R7
  AST_TOP_PRIV_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    take && (&iopl_i) |=> !fault_o); // R8
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_o && !push_ready_i |=> push_valid_o && $stable(push_data_o)); // R10
  AST_PUSH_BLOCKS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_o |-> !op_ready_o); // R10
  AST_CLEAR_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    take && vme_i && op_code_i == 2'd0 |=> !fault_o); // R11
endmodule

bind vif_unit vif_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .vme_i(vme_i), .iopl_i(iopl_i),
  .op_valid_i(op_valid_i), .op_ready_o(op_ready_o), .op_code_i(op_code_i),
  .push_valid_o(push_valid_o), .push_ready_i(push_ready_i),
  .push_data_o(push_data_o), .vip_wr_i(vip_wr_i), .flags_o(flags_o),
  .fault_o(fault_o)
);

// File: tb/vif_unit_tb_top.sv
module vif_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vme_i = 1'b0;
  logic [1:0]  iopl_i = 2'd0;
  logic [15:0] base_flags_i = 16'h0;
  logic        op_valid_i = 1'b0;
  logic        op_ready_o;
  logic [1:0]  op_code_i = 2'd0;
  logic        pop_if_i = 1'b0;
  logic        push_valid_o;
  logic        push_ready_i = 1'b0;
  logic [15:0] push_data_o;
  logic        vip_wr_i = 1'b0;
  logic        vip_wdata_i = 1'b0;
  logic [31:0] flags_o;
  logic        fault_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit m_if = 1'b0, m_vif = 1'b0, m_vip = 1'b0;

  always #10 clk = ~clk;

  vif_unit dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] image(input logic [15:0] base, input bit ifb,
                                        input logic [1:0] pl);
    logic [15:0] r;
    r = base;
    r[9] = ifb;
    r[13:12] = pl;
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic vip_write(input bit v);
    @(negedge clk);
    vip_wr_i = 1'b1; vip_wdata_i = v;
    @(negedge clk);
    vip_wr_i = 1'b0;
    m_vip = v;
    check(flags_o[20] == v, "R6", "vip after write", flags_o[20], v);
  endtask

  task automatic run_op(input bit vme, input logic [1:0] pl, input logic [1:0] op,
                        input bit pif, input logic [15:0] base, input int stall);
    bit e_fault, e_push, n_if, n_vif;
    logic [15:0] e_img;
    string rq;
    e_fault = 0; e_push = 0; n_if = m_if; n_vif = m_vif; e_img = '0;
    if (pl == 2'd3) begin
      rq = "R8";
      case (op)
        2'd0: n_if = 0;
        2'd1: n_if = 1;
        2'd2: begin e_push = 1; e_img = image(base, m_if, pl); end
        default: n_if = pif;
      endcase
    end else if (!vme) begin
      rq = "R7"; e_fault = 1;
    end else begin
      case (op)
        2'd0: begin rq = "R11"; n_vif = 0; end
        2'd1: begin rq = m_vip ? "R5" : "R2";
                    if (m_vip) e_fault = 1; else n_vif = 1; end
        2'd2: begin rq = "R3"; e_push = 1; e_img = image(base, m_vif, pl); end
        default: begin rq = (pif && m_vip) ? "R5" : "R4";
                       if (pif && m_vip) e_fault = 1; else n_vif = pif; end
      endcase
    end
    @(negedge clk);
    check(op_ready_o == 1'b1, "R10", "ready before op", op_ready_o, 1);
    vme_i = vme; iopl_i = pl; op_code_i = op; pop_if_i = pif; base_flags_i = base;
    op_valid_i = 1'b1;
    @(negedge clk);
    op_valid_i = 1'b0;
    m_if = n_if; m_vif = n_vif;
    check(fault_o == e_fault, rq, "fault", fault_o, e_fault);
    check(flags_o[9] == m_if, rq, "IF", flags_o[9], m_if);
    check(flags_o[19] == m_vif, rq, "VIF", flags_o[19], m_vif);
    check(flags_o[20] == m_vip, "R6", "VIP after op", flags_o[20], m_vip);
    check(push_valid_o == e_push, rq, "push valid", push_valid_o, e_push);
    if (e_push) begin
      check(push_data_o == e_img, rq, "push image", push_data_o, e_img);
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        check(push_valid_o && push_data_o == e_img, "R10", "held image",
              push_data_o, e_img);
        check(op_ready_o == 1'b0, "R10", "ready while pending", op_ready_o, 0);
      end
      push_ready_i = 1'b1;
      @(negedge clk);
      push_ready_i = 1'b0;
      check(push_valid_o == 1'b0, "R10", "valid after take", push_valid_o, 0);
    end else if (e_fault) begin
      @(negedge clk);
      check(fault_o == 1'b0, "R9", "fault pulse ended", fault_o, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags_o == 32'h0 && !fault_o && !push_valid_o, "R1", "reset state",
          flags_o, 0);
    // directed corners
    run_op(1, 2'd1, 2'd1, 0, 16'h0002, 0);   // R2 set VIF
    run_op(1, 2'd0, 2'd2, 0, 16'hFFFF, 2);   // R3 push VIF
    run_op(1, 2'd0, 2'd0, 0, 16'h0, 0);      // R2 clear VIF
    vip_write(1'b1);
    run_op(1, 2'd2, 2'd1, 0, 16'h0, 0);      // R5 set under VIP
    run_op(1, 2'd2, 2'd3, 1, 16'h0, 0);      // R5 pop under VIP
    run_op(1, 2'd2, 2'd0, 0, 16'h0, 0);      // R11 clear under VIP
    run_op(1, 2'd2, 2'd3, 0, 16'h0, 0);      // R11 pop 0 under VIP
    run_op(0, 2'd0, 2'd2, 0, 16'h0, 0);      // R7 push faults
    run_op(1, 2'd3, 2'd1, 0, 16'h0, 0);      // R8 set IF
    run_op(0, 2'd3, 2'd2, 0, 16'h1234, 1);   // R8 push IF
    vip_write(1'b0);
    run_op(1, 2'd0, 2'd3, 1, 16'h0, 0);      // R4 pop sets VIF
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 9) == 0) vip_write(1'($urandom_range(0, 1)));
      run_op(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
             2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             16'($urandom), $urandom_range(0, 3));
    end
    finish_run();
  end
endmodule